// File: doc/BRIEF.md
# Decimal Descriptor-List Word Mover

This engine copies whole signed ten-digit words between one contiguous block of memory and a number of separate regions. Every address is a four-digit packed BCD number. The regions are listed in memory as a chain of descriptor words. Each descriptor names the first and last address of one region. The descriptor's sign nibble says whether another descriptor follows it or whether the chain ends there.

In gather mode the engine reads each region in turn and packs its words into the block. In scatter mode it reads the block in sequence and spreads the words out over the regions. The block's starting address is not given directly. It is taken from an index word, which is picked by a two-digit selector. The engine checks every descriptor before it moves any word for it, and it stops with an error code if the descriptor is malformed.

After each stored word the engine can pause for one cycle at a safe point, so that a pending interrupt can be taken. The engine is started with a one-cycle command and reports its outcome with a done pulse and a result code.

Top module: `dec_gather_scatter`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `safePoint`, `memRd` and `memWr` are 0 and `result` is 0, until the first `start`.
- R2: A word is 44 bits. Digit k (k = 0..9) sits at bits [43-4k:40-4k] and the sign nibble sits at bits [3:0]. `memAddr` is the binary value of the four-digit BCD address being accessed. Read data arrives on `memRdData` one cycle after `memRd`.
- R3: A `start` with `indexSel` equal to 00 finishes with `result` = 2 (index error). No memory is accessed, `listPtr` equals `listAddr` and `blockAddr` is 0.
- R4: The block start address is digits 2..5 (bits [35:20]) of the word at address `indexSel`.
- R5: In gather mode (`scatter`=0), for each descriptor the words at region addresses start..stop (inclusive, ascending) are written to consecutive block addresses.
- R6: In scatter mode (`scatter`=1), consecutive block words are written to region addresses start..stop (inclusive, ascending).
- R7: A descriptor's start is digits 2..5 and its stop is digits 6..9. Descriptors are fetched from consecutive addresses starting at `listAddr`. Sign 4'hD ends the chain after its region, and any other valid sign continues with the next descriptor.
- R8: A descriptor with sign 4'hE, or with start greater than stop, ends the operation with `result` = 1 before it moves any word. Words already moved for earlier descriptors remain in place.
- R9: At completion `listPtr` is one more than the address of the last descriptor fetched, including a rejected one.
- R10: After a normal finish (`result` = 0) `blockAddr` is 0. After a descriptor error it holds the next unfilled block address.
- R11: Block, region and list addresses advance in decimal and wrap from 9999 to 0000.
- R12: When `irqPending` is high in the cycle in which a word is written, `safePoint` is high for exactly the next cycle. In that cycle there is no memory access. The operation then continues unchanged.
- R13: `busy` is high from the cycle after `start` until the cycle after `done`. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted while idle) |
| scatter | input | 1 | 1 = scatter, 0 = gather |
| listAddr | input | 16 | BCD address of the first descriptor |
| indexSel | input | 8 | BCD address of the index word |
| irqPending | input | 1 | An interrupt is waiting for a safe point |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write request |
| memAddr | output | 14 | Binary word address |
| memWrData | output | 44 | Write data |
| memRdData | input | 44 | Read data, one cycle after memRd |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 descriptor error, 2 index error |
| safePoint | output | 1 | One-cycle interrupt window |
| listPtr | output | 16 | BCD descriptor pointer |
| blockAddr | output | 16 | BCD block address |

## Verification
If the region working address or the block address goes wrong, the fault shows up on `memAddr` at the next write. A bad descriptor capture changes the word count before `done`, and the final memory image shows it as well. A stale end-of-region flag carried across a safe point only becomes visible as an extra or missing word once the engine resumes, so bursts of safe points are mixed into the random runs. A bad pointer or result register is seen only at `done`, through `listPtr`, `blockAddr` and `result`.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_DESC = 2'd1, RES_IDX = 2'd2} gsResult_e;
  typedef enum logic [1:0] {ADR_INDEX, ADR_LIST, ADR_REGION, ADR_BLOCK} gsAddrSel_e;

  typedef struct packed {
    logic       loadStart;
    logic       loadBlock;
    logic       loadDesc;
    logic       listStep;
    logic       wordStep;
    logic       clearBlock;
    logic       setResult;
    gsResult_e  resultVal;
    gsAddrSel_e addrSel;
    logic       memRd;
    logic       memWr;
  } gsStrobe_t;

  localparam logic [3:0] SIGN_MINUS = 4'hD;
  localparam logic [3:0] SIGN_ALPHA = 4'hE;
endpackage

// File: rtl/gs_bcd_inc.sv
module gs_bcd_inc #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] valIn,
  output logic [4*DIGITS-1:0] valOut
);
  logic [DIGITS-1:0] carry;
  assign carry[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    logic [3:0] cur;
    assign cur = valIn[4*g +: 4];
    assign valOut[4*g +: 4] = carry[g] ? ((cur == 4'd9) ? 4'd0 : cur + 4'd1) : cur;
    if (g < DIGITS - 1) begin : gCarry
      assign carry[g+1] = carry[g] && (cur == 4'd9);
    end
  end
endmodule

// File: rtl/gs_datapath.sv
module gs_datapath
  import gs_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int SEL_DIGITS = 2,
  parameter int WORD_W = 44,
  parameter int ADDR_W = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gsStrobe_t             strobe,
  input  logic [4*DIGITS-1:0]   listAddrIn,
  input  logic [4*SEL_DIGITS-1:0] indexSelIn,
  input  logic [WORD_W-1:0]     memRdData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [WORD_W-1:0]     memWrData,
  output logic                  indexZero,
  output logic                  descBad,
  output logic                  descLast,
  output logic                  atStop,
  output logic [4*DIGITS-1:0]   listPtr,
  output logic [4*DIGITS-1:0]   blockAddr,
  output gsResult_e             result
);
  localparam int FIELD_W   = 4 * DIGITS;
  localparam int SEL_W     = 4 * SEL_DIGITS;
  localparam int START_LSB = WORD_W - 8 - FIELD_W;
  localparam int STOP_LSB  = 4;

  logic [FIELD_W-1:0] blockReg, workReg, stopReg;
  logic [FIELD_W-1:0] listNext, blockNext, workNext;
  logic [SEL_W-1:0]   selReg;
  logic               lastReg;
  gsResult_e          resultReg;
  logic [FIELD_W-1:0] rdStart, rdStop;
  logic [3:0]         rdSign;

  function automatic logic [ADDR_W-1:0] toBin(input logic [FIELD_W-1:0] v);
    logic [ADDR_W-1:0] acc;
    acc = '0;
    for (int i = DIGITS - 1; i >= 0; i--) acc = acc * ADDR_W'(10) + ADDR_W'(v[4*i +: 4]);
    return acc;
  endfunction

  gs_bcd_inc #(.DIGITS(DIGITS)) uListInc  (.valIn(listPtr),  .valOut(listNext));
  gs_bcd_inc #(.DIGITS(DIGITS)) uBlockInc (.valIn(blockReg), .valOut(blockNext));
  gs_bcd_inc #(.DIGITS(DIGITS)) uWorkInc  (.valIn(workReg),  .valOut(workNext));

  assign rdStart   = memRdData[START_LSB +: FIELD_W];
  assign rdStop    = memRdData[STOP_LSB +: FIELD_W];
  assign rdSign    = memRdData[3:0];
  assign descBad   = (rdSign == SIGN_ALPHA) || (rdStart > rdStop);
  assign indexZero = (indexSelIn == '0);
  assign descLast  = lastReg;
  assign atStop    = (workReg == stopReg);
  assign memWrData = memRdData;
  assign blockAddr = blockReg;
  assign result    = resultReg;

  always_comb begin
    unique case (strobe.addrSel)
      ADR_INDEX:  memAddr = toBin({{(FIELD_W-SEL_W){1'b0}}, selReg});
      ADR_LIST:   memAddr = toBin(listPtr);
      ADR_REGION: memAddr = toBin(workReg);
      default:    memAddr = toBin(blockReg);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      listPtr   <= '0;
      blockReg  <= '0;
      workReg   <= '0;
      stopReg   <= '0;
      selReg    <= '0;
      lastReg   <= 1'b0;
      resultReg <= RES_OK;
    end else begin
      if (strobe.loadStart) begin
        listPtr  <= listAddrIn;
        selReg   <= indexSelIn;
        blockReg <= '0;
      end
      if (strobe.loadBlock) blockReg <= memRdData[START_LSB +: FIELD_W];
      if (strobe.listStep)  listPtr  <= listNext;
      if (strobe.loadDesc) begin
        workReg <= rdStart;
        stopReg <= rdStop;
        lastReg <= (rdSign == SIGN_MINUS);
      end
      if (strobe.wordStep) begin
        workReg  <= workNext;
        blockReg <= blockNext;
      end
      if (strobe.clearBlock) blockReg  <= '0;
      if (strobe.setResult)  resultReg <= strobe.resultVal;
    end
  end

  assert_ok_clears_block_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setResult && strobe.resultVal == RES_OK) |=> (blockReg == '0));
  assert_desc_checked_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDesc |-> !descBad);
  assert_ptr_moves_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.listStep |=> (listPtr != $past(listPtr)));
endmodule

// File: rtl/gs_control.sv
module gs_control
  import gs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      scatter,
  input  logic      irqPending,
  input  logic      indexZero,
  input  logic      descBad,
  input  logic      descLast,
  input  logic      atStop,
  output gsStrobe_t strobe,
  output logic      busy,
  output logic      done,
  output logic      safePoint
);
  typedef enum logic [3:0] {
    S_IDLE, S_IDX_RD, S_IDX_WAIT, S_DESC_RD, S_DESC_WAIT,
    S_DATA_RD, S_DATA_WAIT, S_SAFE, S_FINISH
  } gsState_e;

  gsState_e  state, nextState;
  logic      scatReg, endHeld, wordEnd;
  gsStrobe_t st;

  always_comb begin
    st           = '0;
    st.addrSel   = ADR_LIST;
    st.resultVal = RES_OK;
    nextState    = state;
    wordEnd      = (state == S_SAFE) ? endHeld : atStop;
    unique case (state)
      S_IDLE: if (start) begin
        st.loadStart = 1'b1;
        if (indexZero) begin
          st.setResult = 1'b1;
          st.resultVal = RES_IDX;
          nextState    = S_FINISH;
        end else nextState = S_IDX_RD;
      end
      S_IDX_RD: begin
        st.memRd   = 1'b1;
        st.addrSel = ADR_INDEX;
        nextState  = S_IDX_WAIT;
      end
      S_IDX_WAIT: begin
        st.loadBlock = 1'b1;
        nextState    = S_DESC_RD;
      end
      S_DESC_RD: begin
        st.memRd    = 1'b1;
        st.listStep = 1'b1;
        nextState   = S_DESC_WAIT;
      end
      S_DESC_WAIT: begin
        if (descBad) begin
          st.setResult = 1'b1;
          st.resultVal = RES_DESC;
          nextState    = S_FINISH;
        end else begin
          st.loadDesc = 1'b1;
          nextState   = S_DATA_RD;
        end
      end
      S_DATA_RD: begin
        st.memRd   = 1'b1;
        st.addrSel = scatReg ? ADR_BLOCK : ADR_REGION;
        nextState  = S_DATA_WAIT;
      end
      S_DATA_WAIT, S_SAFE: begin
        if (state == S_DATA_WAIT) begin
          st.memWr    = 1'b1;
          st.addrSel  = scatReg ? ADR_REGION : ADR_BLOCK;
          st.wordStep = 1'b1;
        end
        if (state == S_DATA_WAIT && irqPending) nextState = S_SAFE;
        else if (!wordEnd)  nextState = S_DATA_RD;
        else if (!descLast) nextState = S_DESC_RD;
        else begin
          st.setResult  = 1'b1;
          st.clearBlock = 1'b1;
          nextState     = S_FINISH;
        end
      end
      S_FINISH: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      scatReg <= 1'b0;
      endHeld <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && start) scatReg <= scatter;
      if (state == S_DATA_WAIT)     endHeld <= atStop;
    end
  end

  assign strobe    = st;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FINISH);
  assign safePoint = (state == S_SAFE);

  assert_rd_wr_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(st.memRd && st.memWr));
  assert_done_single_R13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_safe_after_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    safePoint |-> ($past(st.memWr) && !st.memRd && !st.memWr));
  assert_done_while_busy_R13: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
endmodule

// File: rtl/dec_gather_scatter.sv
module dec_gather_scatter
  import gs_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int SEL_DIGITS = 2,
  parameter int WORD_W = 44,
  parameter int ADDR_W = 14
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    scatter,
  input  logic [4*DIGITS-1:0]     listAddr,
  input  logic [4*SEL_DIGITS-1:0] indexSel,
  input  logic                    irqPending,
  output logic                    memRd,
  output logic                    memWr,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [WORD_W-1:0]       memWrData,
  input  logic [WORD_W-1:0]       memRdData,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              result,
  output logic                    safePoint,
  output logic [4*DIGITS-1:0]     listPtr,
  output logic [4*DIGITS-1:0]     blockAddr
);
  gsStrobe_t strobe;
  gsResult_e resultCode;
  logic      indexZero, descBad, descLast, atStop;

  gs_control uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .scatter(scatter), .irqPending(irqPending),
    .indexZero(indexZero), .descBad(descBad), .descLast(descLast), .atStop(atStop),
    .strobe(strobe), .busy(busy), .done(done), .safePoint(safePoint)
  );

  gs_datapath #(.DIGITS(DIGITS), .SEL_DIGITS(SEL_DIGITS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .listAddrIn(listAddr), .indexSelIn(indexSel),
    .memRdData(memRdData), .memAddr(memAddr), .memWrData(memWrData),
    .indexZero(indexZero), .descBad(descBad), .descLast(descLast), .atStop(atStop),
    .listPtr(listPtr), .blockAddr(blockAddr), .result(resultCode)
  );

  assign memRd  = strobe.memRd;
  assign memWr  = strobe.memWr;
  assign result = resultCode;
endmodule

// File: tb/sim_dec_gather_scatter.sv
`timescale 1ns/1ps
module sim_dec_gather_scatter;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, scatter = 1'b0, irqPending = 1'b0;
  logic [15:0] listAddr = '0;
  logic [7:0]  indexSel = '0;
  logic memRd, memWr, busy, done, safePoint;
  logic [13:0] memAddr;
  logic [43:0] memWrData, memRdData = '0;
  logic [1:0]  result;
  logic [15:0] listPtr, blockAddr;

  int total = 0, bad = 0, writes = 0, irqPct = 0;
  bit expectSafe = 0;
  logic [43:0] mem [int];
  logic [43:0] refMem [int];

  always #2 clk = ~clk;

  dec_gather_scatter u0 (.*);

  always @(posedge clk) begin
    if (memWr) mem[int'(memAddr)] = memWrData;
    if (memRd) memRdData <= mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : '0;
  end

  always @(posedge clk) begin
    #1;
    irqPending = ($urandom_range(0, 99) < irqPct);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    if (expectSafe) begin
      check(safePoint && !memRd && !memWr, "R12 safe point window", int'(safePoint), 1);
      expectSafe = 0;
    end else if (safePoint) check(0, "R12 unexpected safe point", 1, 0);
    if (memWr) begin
      writes++;
      if (irqPending) expectSafe = 1;
    end
  end

  function automatic logic [15:0] toBcd(input int v);
    logic [15:0] b;
    for (int i = 0; i < 4; i++) begin b[4*i +: 4] = 4'(v % 10); v = v / 10; end
    return b;
  endfunction

  function automatic int fromBcd(input logic [15:0] b);
    int v = 0;
    for (int i = 3; i >= 0; i--) v = v * 10 + int'(b[4*i +: 4]);
    return v;
  endfunction

  function automatic logic [43:0] mkDesc(input int st, input int sp, input logic [3:0] sg);
    return {8'h00, toBcd(st), toBcd(sp), sg};
  endfunction

  function automatic logic [43:0] mkIdx(input int b);
    return {8'h00, toBcd(b), 16'h0000, 4'hC};
  endfunction

  task automatic put(input int a, input logic [43:0] w);
    mem[a] = w;
    refMem[a] = w;
  endtask

  function automatic logic [43:0] rdRef(input int a);
    return refMem.exists(a) ? refMem[a] : 44'h0;
  endfunction

  task automatic refRun(input bit scat, input int list, input int sel,
                        output int res, output int ptr, output int blk, output int words);
    logic [43:0] d;
    int st, sp, work;
    ptr = list; blk = 0; words = 0; res = 0;
    if (sel == 0) begin res = 2; return; end
    blk = fromBcd(rdRef(sel)[35:20]);
    forever begin
      d = rdRef(ptr);
      ptr = (ptr + 1) % 10000;
      st = fromBcd(d[35:20]); sp = fromBcd(d[19:4]);
      if (d[3:0] == 4'hE || st > sp) begin res = 1; return; end
      work = st;
      forever begin
        if (scat) refMem[work] = rdRef(blk);
        else refMem[blk] = rdRef(work);
        words++;
        blk = (blk + 1) % 10000;
        if (work == sp) break;
        work = (work + 1) % 10000;
      end
      if (d[3:0] == 4'hD) begin blk = 0; return; end
    end
  endtask

  task automatic runOp(input string tag, input bit scat, input int list, input int sel);
    int eRes, ePtr, eBlk, eWords, guard, miss;
    refRun(scat, list, sel, eRes, ePtr, eBlk, eWords);
    @(negedge clk);
    scatter = scat; listAddr = toBcd(list); indexSel = {toBcd(sel)[7:0]};
    start = 1'b1; writes = 0;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, {tag, " R13 busy after start"}, int'(busy), 1);
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    check(int'(result) == eRes, {tag, " result"}, int'(result), eRes);
    check(fromBcd(listPtr) == ePtr, {tag, " R9 listPtr"}, fromBcd(listPtr), ePtr);
    check(fromBcd(blockAddr) == eBlk, {tag, " R10 blockAddr"}, fromBcd(blockAddr), eBlk);
    check(writes == eWords, {tag, " word count"}, writes, eWords);
    miss = 0;
    foreach (refMem[k]) if (!mem.exists(k) || mem[k] !== refMem[k]) miss++;
    foreach (mem[k]) if (!refMem.exists(k)) miss++;
    check(miss == 0, {tag, " R2 memory image"}, miss, 0);
    @(negedge clk);
    check(!done && !busy, {tag, " R13 done pulse ends"}, int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R13 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check(!busy && !done && !safePoint && !memRd && !memWr && result == 2'd0, "R1 in reset", int'(busy), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !safePoint && !memRd && !memWr && result == 2'd0, "R1 after reset", int'(busy), 0);

    runOp("R3 index zero", 1'b0, 5000, 0);

    put(7, mkIdx(6100));
    put(5100, mkDesc(1200, 1202, 4'hD));
    for (int a = 1200; a <= 1202; a++) put(a, {8'h12, toBcd(a), 16'h5555, 4'hC});
    runOp("R4 R5 gather", 1'b0, 5100, 7);

    put(8, mkIdx(6200));
    put(5200, mkDesc(1300, 1301, 4'hC));
    put(5201, mkDesc(1400, 1402, 4'hD));
    put(5202, mkDesc(1500, 1509, 4'hD));
    for (int k = 0; k < 6; k++) put(6200 + k, {8'h34, toBcd(k), 16'h7777, 4'hD});
    runOp("R6 R7 scatter chain", 1'b1, 5200, 8);

    put(10, mkIdx(6300));
    put(5300, mkDesc(1500, 1501, 4'hC));
    put(5301, mkDesc(1600, 1601, 4'hE));
    runOp("R8 alpha descriptor", 1'b0, 5300, 10);

    put(11, mkIdx(6400));
    put(5400, mkDesc(1700, 1699, 4'hC));
    runOp("R8 start above stop", 1'b0, 5400, 11);

    put(9, mkIdx(9998));
    put(5500, mkDesc(1800, 1803, 4'hD));
    runOp("R11 block wrap", 1'b0, 5500, 9);

    put(9999, mkDesc(1900, 1900, 4'hC));
    put(0, mkDesc(1901, 1902, 4'hD));
    put(12, mkIdx(6500));
    runOp("R11 list wrap", 1'b0, 9999, 12);

    irqPct = 100;
    put(13, mkIdx(6600));
    put(5600, mkDesc(2000, 2000, 4'hC));
    put(5601, mkDesc(2001, 2003, 4'hD));
    runOp("R12 safe point every word", 1'b1, 5600, 13);

    for (int n = 0; n < 40; n++) begin
      int sel, blk, list, cnt, st, sp;
      logic [3:0] sg;
      irqPct = ($urandom_range(0, 1) == 1) ? 40 : 0;
      sel = $urandom_range(1, 99);
      blk = $urandom_range(6000, 8980);
      put(sel, mkIdx(blk));
      list = $urandom_range(5000, 5900);
      cnt = $urandom_range(1, 3);
      for (int k = 0; k < 16; k++) put(blk + k, {$urandom, $urandom}[43:0]);
      for (int i = 0; i < cnt; i++) begin
        st = $urandom_range(1001, 4990);
        sp = st + $urandom_range(0, 4);
        sg = (i == cnt - 1) ? 4'hD : 4'hC;
        if ($urandom_range(0, 9) == 0) sg = 4'hE;
        else if ($urandom_range(0, 9) == 0) sp = st - 1;
        put(list + i, mkDesc(st, sp, sg));
        for (int a = st; a <= st + 4; a++) put(a, {$urandom, $urandom}[43:0]);
      end
      runOp("R5 R6 R7 random", 1'($urandom_range(0, 1)), list, sel);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule